// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block arbitrates eight interrupt sources for a small CPU core. There are four external request pins, three timer overflow flags and one serial-port flag. It presents the CPU sequencer with one request at a time. Each request comes with a fixed vector address and the priority level it was granted at. Every source has its own enable bit and a one-bit priority, and a global enable gates them all. The enable and priority bits of the two extra external inputs live in a separate extended control register, together with their trigger-type bits and their pending flags. Those two inputs are polled after the six standard sources.

External inputs are active low. Each one is either level triggered, in which case its request follows the sampled pin, or falling-edge triggered, in which case a latched flag is set on a detected edge and cleared when the CPU vectors to it. The CPU pulses `irq_ack` when it takes the presented vector and `irq_ret` when a handler returns. The block keeps one in-service bit per level, so that a high-level request can preempt a low-level handler and nothing else preempts. Timer 0 and timer 1 overflow flags live outside the block, and a clear strobe is returned for them when they are vectored.

Top module: `irq_ctl8`

## Requirements
- R1: After synchronous reset the three register readbacks are 00h, no request is presented, both in-service bits are 0, both INT0/INT1 flags are 0 and no timer clear strobe is active.
- R2: Source index i (0 INT0, 1 timer 0, 2 INT1, 3 timer 1, 4 serial, 5 timer 2, 6 INT2, 7 INT3) is presented with vector 8*i+3, i.e. 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h, 3Bh.
- R3: The enable register bit 7 is the global enable, and bits 5..0 enable sources 5..0 in index order; extended register bit 2 enables INT2 and bit 6 enables INT3. A source whose enable is 0, or any source while the global enable is 0, is never presented.
- R4: Among pending sources of the same level, the one with the lowest index is presented.
- R5: Priority register bits 5..0 and extended register bits 3 (INT2) and 7 (INT3) mark a source high priority when 1. A pending high source wins over any low source and is presented while only the low level is in service, with `irq_hi` = 1. No request is presented while the high level is in service. Only high requests are presented while the low level is in service.
- R6: An `irq_ack` while a request is presented sets the in-service bit of that request's level one cycle later. Each `irq_ret` clears the high in-service bit if it is set, and otherwise the low one.
- R7: With the type bit 1 (INT0/INT1: `ext01_type`; INT2: extended bit 0; INT3: extended bit 4), a pin sampled 1 and then 0 on the next clock sets that input's flag. The flag is readable on `ext01_flag` or at extended bits 1/5, and an acknowledge of that source clears it. A pin held low sets no further flag.
- R8: With the type bit 0, the request follows the sampled pin, with one cycle of latency: pin low means a request. No flag is ever latched, and an acknowledge leaves the request in place while the pin stays low.
- R9: `tmr_clr[0]` (timer 0) and `tmr_clr[1]` (timer 1) pulse combinationally during an acknowledge of that source only. Serial and timer 2 requests follow their inputs and stay pending after being acknowledged.
- R10: Register writes use `cfg_sel` 0 = enable, 1 = priority, 2 = extended. Enable bit 6 and priority bits 7..6 always read 0. Writing extended bits 1/5 sets or clears the INT2/INT3 flag while that input is in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 priority, 2 extended |
| cfg_wdata | input | 8 | Register write data |
| ien_q | output | 8 | Enable register readback |
| ipri_q | output | 8 | Priority register readback |
| xctl_q | output | 8 | Extended register readback with live INT2/INT3 flags |
| ext_pin_n | input | 4 | External request pins, active low (INT0, INT1, INT2, INT3) |
| ext01_type | input | 2 | Trigger type of INT0/INT1, 1 = falling edge |
| ext01_flag | output | 2 | Edge flags of INT0/INT1 |
| tmr_ovf | input | 3 | Overflow flags of timers 0, 1, 2 |
| ser_flag | input | 1 | Serial port request flag |
| tmr_clr | output | 2 | Flag clear strobes for timers 0, 1 |
| irq_ack | input | 1 | CPU takes the presented vector |
| irq_ret | input | 1 | CPU returns from a handler |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 8 | Vector address of the presented request |
| irq_hi | output | 1 | Presented request is at the high level |
| svc_hi | output | 1 | High level in service |
| svc_lo | output | 1 | Low level in service |

## Verification
The assertions check, on every cycle, the structural properties of arbitration. No request appears while the high level is in service, and only high requests appear during a low handler. Vectors keep their 8*i+3 form, and the global mask holds. An acknowledge sets the matching in-service bit, a return clears the top one, a sampled falling edge in edge mode latches its flag, and timer clear strobes appear only with an acknowledge. Other behaviour needs the bench's scenarios. That covers the full polling order and priority selection, which a sweep of every source combination under several priority patterns exercises. It also covers nested preemption followed by unwinding, the absence of retriggering while a pin is held low, level-mode persistence after an acknowledge, and software access to the extended flags.

// File: rtl/irq_ctl8_pkg.sv
`timescale 1ns/1ps
package irq_ctl8_pkg;

    localparam int NSRC       = 8;
    localparam int NEXT       = 4;
    localparam int SRC_W      = $clog2(NSRC);
    localparam int VEC_W      = 8;
    localparam int VEC_STRIDE = 8;
    localparam int VEC_OFS    = 3;

    // source indices in polling order (0 = polled first)
    localparam int SRC_X0  = 0;
    localparam int SRC_T0  = 1;
    localparam int SRC_X1  = 2;
    localparam int SRC_T1  = 3;
    localparam int SRC_SER = 4;
    localparam int SRC_T2  = 5;
    localparam int SRC_X2  = 6;
    localparam int SRC_X3  = 7;

    typedef enum logic [1:0] {
        SEL_ENA  = 2'd0,
        SEL_PRI  = 2'd1,
        SEL_XCTL = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic gen;
        logic rsvd;
        logic et2;
        logic es;
        logic et1;
        logic ex1;
        logic et0;
        logic ex0;
    } ien_t;

    typedef struct packed {
        logic [1:0] rsvd;
        logic pt2;
        logic ps;
        logic pt1;
        logic px1;
        logic pt0;
        logic px0;
    } ipri_t;

    // extended register without its two flag bits (those live with the edge logic)
    typedef struct packed {
        logic px3;
        logic ex3;
        logic it3;
        logic px2;
        logic ex2;
        logic it2;
    } xcfg_t;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] idx;
    } pick_t;

    localparam logic [7:0] ENA_MASK = 8'hBF;
    localparam logic [7:0] PRI_MASK = 8'h3F;

    // lowest set index wins
    function automatic pick_t first_set(input logic [NSRC-1:0] v);
        pick_t p;
        p.valid = 1'b0;
        p.idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.idx   = SRC_W'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_W'(int'(idx) * VEC_STRIDE + VEC_OFS);
    endfunction

    // external input k -> source index
    function automatic int ext_src(input int k);
        case (k)
            0:       return SRC_X0;
            1:       return SRC_X1;
            2:       return SRC_X2;
            default: return SRC_X3;
        endcase
    endfunction

endpackage

// File: rtl/irq_ctl8_regs.sv
`timescale 1ns/1ps
module irq_ctl8_regs
    import irq_ctl8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    output ien_t       ien_q,
    output ipri_t      ipri_q,
    output xcfg_t      xcfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q  <= '0;
            ipri_q <= '0;
            xcfg_q <= '0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_ENA:  ien_q  <= ien_t'(wdata & ENA_MASK);
                SEL_PRI:  ipri_q <= ipri_t'(wdata & PRI_MASK);
                SEL_XCTL: xcfg_q <= '{px3: wdata[7], ex3: wdata[6], it3: wdata[4],
                                      px2: wdata[3], ex2: wdata[2], it2: wdata[0]};
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/irq_ctl8_edge.sv
`timescale 1ns/1ps
module irq_ctl8_edge
    import irq_ctl8_pkg::*;
#(
    parameter int N = NEXT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin_n,
    input  logic [N-1:0] edge_mode,
    input  logic [N-1:0] ack_clr,
    input  logic [N-1:0] sw_we,
    input  logic [N-1:0] sw_val,
    output logic [N-1:0] req,
    output logic [N-1:0] flag
);

    for (genvar k = 0; k < N; k++) begin : g_pin
        logic smp_q;
        logic prev_q;
        logic flag_q;
        logic fall;

        assign fall = prev_q & ~smp_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                smp_q  <= 1'b1;
                prev_q <= 1'b1;
                flag_q <= 1'b0;
            end else begin
                smp_q  <= pin_n[k];
                prev_q <= smp_q;
                if (!edge_mode[k])
                    flag_q <= 1'b0;
                else if (fall)
                    flag_q <= 1'b1;
                else if (ack_clr[k])
                    flag_q <= 1'b0;
                else if (sw_we[k])
                    flag_q <= sw_val[k];
            end
        end

        assign req[k]  = edge_mode[k] ? flag_q : ~smp_q;
        assign flag[k] = flag_q;

        // R7: a sampled 1-then-0 in edge mode latches the flag
        assert_edge_latch_R7: assert property (@(posedge clk) disable iff (rst)
            (edge_mode[k] && prev_q && !smp_q) |=> flag_q);

        // R8: level mode never holds a flag
        assert_level_noflag_R8: assert property (@(posedge clk) disable iff (rst)
            !edge_mode[k] |=> !flag_q);
    end

endmodule

// File: rtl/irq_ctl8_arb.sv
`timescale 1ns/1ps
module irq_ctl8_arb
    import irq_ctl8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC-1:0]  pri,
    input  logic             ack,
    input  logic             ret,
    output logic             irq_req,
    output logic             irq_hi,
    output logic [VEC_W-1:0] irq_vec,
    output logic [SRC_W-1:0] win_idx,
    output logic             fire,
    output logic             svc_hi,
    output logic             svc_lo
);

    pick_t pick_h;
    pick_t pick_l;
    logic  hi_d;
    logic  lo_d;

    assign pick_h = first_set(pend & pri);
    assign pick_l = first_set(pend & ~pri);

    always_comb begin
        irq_req = 1'b0;
        irq_hi  = 1'b0;
        win_idx = '0;
        if (!svc_hi) begin
            if (pick_h.valid) begin
                irq_req = 1'b1;
                irq_hi  = 1'b1;
                win_idx = pick_h.idx;
            end else if (!svc_lo && pick_l.valid) begin
                irq_req = 1'b1;
                win_idx = pick_l.idx;
            end
        end
    end

    assign irq_vec = irq_req ? vec_of(win_idx) : '0;
    assign fire    = ack & irq_req;

    always_comb begin
        hi_d = svc_hi;
        lo_d = svc_lo;
        if (ret) begin
            if (svc_hi) hi_d = 1'b0;
            else        lo_d = 1'b0;
        end
        if (fire) begin
            if (irq_hi) hi_d = 1'b1;
            else        lo_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            svc_hi <= hi_d;
            svc_lo <= lo_d;
        end
    end

    assert_hi_blocks_R5: assert property (@(posedge clk) disable iff (rst)
        svc_hi |-> !irq_req);

    assert_lo_only_hi_R5: assert property (@(posedge clk) disable iff (rst)
        (svc_lo && irq_req) |-> irq_hi);

    assert_vec_form_R2: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec[2:0] == 3'(VEC_OFS) && irq_vec < VEC_W'(NSRC * VEC_STRIDE)));

    assert_ack_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && irq_hi) |=> svc_hi);

    assert_ack_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (fire && !irq_hi) |=> svc_lo);

    assert_ret_top_R6: assert property (@(posedge clk) disable iff (rst)
        (ret && svc_hi && !fire) |=> !svc_hi);

endmodule

// File: rtl/irq_ctl8.sv
`timescale 1ns/1ps
module irq_ctl8
    import irq_ctl8_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] ien_q,
    output logic [7:0] ipri_q,
    output logic [7:0] xctl_q,
    input  logic [3:0] ext_pin_n,
    input  logic [1:0] ext01_type,
    output logic [1:0] ext01_flag,
    input  logic [2:0] tmr_ovf,
    input  logic       ser_flag,
    output logic [1:0] tmr_clr,
    input  logic       irq_ack,
    input  logic       irq_ret,
    output logic       irq_req,
    output logic [7:0] irq_vec,
    output logic       irq_hi,
    output logic       svc_hi,
    output logic       svc_lo
);

    ien_t             ien;
    ipri_t            ipri;
    xcfg_t            xcfg;
    logic [NEXT-1:0]  ext_mode;
    logic [NEXT-1:0]  ext_req;
    logic [NEXT-1:0]  ext_flag;
    logic [NEXT-1:0]  ext_clr;
    logic [NEXT-1:0]  sw_we;
    logic [NEXT-1:0]  sw_val;
    logic [NSRC-1:0]  raw;
    logic [NSRC-1:0]  src_en;
    logic [NSRC-1:0]  src_pri;
    logic [NSRC-1:0]  pend;
    logic [SRC_W-1:0] win_idx;
    logic             fire;
    logic             xctl_wr;

    irq_ctl8_regs i_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .wdata  (cfg_wdata),
        .ien_q  (ien),
        .ipri_q (ipri),
        .xcfg_q (xcfg)
    );

    assign xctl_wr  = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_XCTL);
    assign ext_mode = {xcfg.it3, xcfg.it2, ext01_type};
    assign sw_we    = {xctl_wr, xctl_wr, 2'b00};
    assign sw_val   = {cfg_wdata[5], cfg_wdata[1], 2'b00};

    for (genvar k = 0; k < NEXT; k++) begin : g_clr
        assign ext_clr[k] = fire && (win_idx == SRC_W'(ext_src(k)));
    end

    irq_ctl8_edge #(.N(NEXT)) i_edge (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_pin_n),
        .edge_mode (ext_mode),
        .ack_clr   (ext_clr),
        .sw_we     (sw_we),
        .sw_val    (sw_val),
        .req       (ext_req),
        .flag      (ext_flag)
    );

    assign raw     = {ext_req[3], ext_req[2], tmr_ovf[2], ser_flag,
                      tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};
    assign src_en  = {xcfg.ex3, xcfg.ex2, ien.et2, ien.es, ien.et1, ien.ex1, ien.et0, ien.ex0};
    assign src_pri = {xcfg.px3, xcfg.px2, ipri.pt2, ipri.ps, ipri.pt1, ipri.px1, ipri.pt0, ipri.px0};
    assign pend    = raw & src_en & {NSRC{ien.gen}};

    irq_ctl8_arb i_arb (
        .clk     (clk),
        .rst     (rst),
        .pend    (pend),
        .pri     (src_pri),
        .ack     (irq_ack),
        .ret     (irq_ret),
        .irq_req (irq_req),
        .irq_hi  (irq_hi),
        .irq_vec (irq_vec),
        .win_idx (win_idx),
        .fire    (fire),
        .svc_hi  (svc_hi),
        .svc_lo  (svc_lo)
    );

    assign tmr_clr    = {fire && (win_idx == SRC_W'(SRC_T1)), fire && (win_idx == SRC_W'(SRC_T0))};
    assign ext01_flag = ext_flag[1:0];
    assign ien_q      = ien;
    assign ipri_q     = ipri;
    assign xctl_q     = {xcfg.px3, xcfg.ex3, ext_flag[3], xcfg.it3,
                         xcfg.px2, xcfg.ex2, ext_flag[2], xcfg.it2};

    // R3: global enable clear masks everything
    assert_global_mask_R3: assert property (@(posedge clk) disable iff (rst)
        !ien_q[7] |-> !irq_req);

    // R9: timer flag clears only come with an acknowledge
    assert_tclr_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (tmr_clr != 2'b00) |-> irq_ack);

endmodule

// File: tb/test_irq_ctl8.sv
`timescale 1ns/1ps
module test_irq_ctl8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] ien_q, ipri_q, xctl_q;
    logic [3:0] ext_pin_n = 4'hF;
    logic [1:0] ext01_type = 2'b00;
    logic [1:0] ext01_flag;
    logic [2:0] tmr_ovf = 3'b000;
    logic       ser_flag = 1'b0;
    logic [1:0] tmr_clr;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;
    logic       irq_hi;
    logic       svc_hi, svc_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_ctl8 i_irq_ctl8 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ien_q(ien_q), .ipri_q(ipri_q), .xctl_q(xctl_q),
        .ext_pin_n(ext_pin_n), .ext01_type(ext01_type), .ext01_flag(ext01_flag),
        .tmr_ovf(tmr_ovf), .ser_flag(ser_flag), .tmr_clr(tmr_clr),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
        .irq_hi(irq_hi), .svc_hi(svc_hi), .svc_lo(svc_lo)
    );

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // drive sources by index (externals in level mode: low = asserted)
    task automatic set_src(input logic [7:0] m);
        tmr_ovf   = {m[5], m[3], m[1]};
        ser_flag  = m[4];
        ext_pin_n = ~{m[7], m[6], m[2], m[0]};
        @(negedge clk);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    // {req, hi, vec} expected from pending mask and priority mask
    function automatic int expect_pick(input logic [7:0] m, input logic [7:0] p);
        for (int i = 0; i < 8; i++)
            if (m[i] && p[i]) return (1 << 9) | (1 << 8) | (8 * i + 3);
        for (int i = 0; i < 8; i++)
            if (m[i]) return (1 << 9) | (8 * i + 3);
        return 0;
    endfunction

    function automatic int outv();
        return {22'd0, irq_req, irq_hi, irq_vec};
    endfunction

    initial begin
        logic [7:0] pats [3];
        pats[0] = 8'h00; pats[1] = 8'h5A; pats[2] = 8'hC3;

        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        chk("R1 ien", ien_q, 0);
        chk("R1 ipri", ipri_q, 0);
        chk("R1 xctl", xctl_q, 0);
        chk("R1 req", irq_req, 0);
        chk("R1 svc", {svc_hi, svc_lo}, 0);
        chk("R1 flags", ext01_flag, 0);
        chk("R1 tclr", tmr_clr, 0);

        // R10 reserved bits read 0
        cfg(2'd0, 8'hFF); chk("R10 ien readback", ien_q, 8'hBF);
        cfg(2'd1, 8'hFF); chk("R10 ipri readback", ipri_q, 8'h3F);
        cfg(2'd2, 8'hFF); chk("R10 xctl readback", xctl_q, 8'hDD);

        // R2 vector per source, all low priority
        cfg(2'd1, 8'h00); cfg(2'd2, 8'h44); cfg(2'd0, 8'hBF);
        for (int i = 0; i < 8; i++) begin
            set_src(8'(1 << i));
            chk("R2 vector", outv(), (1 << 9) | (8 * i + 3));
        end

        // R4 R5 exhaustive sweep of pending masks under three priority patterns
        for (int pi = 0; pi < 3; pi++) begin
            logic [7:0] p;
            p = pats[pi];
            cfg(2'd1, {2'b00, p[5:0]});
            cfg(2'd2, {p[7], 1'b1, 2'b00, p[6], 1'b1, 2'b00});
            for (int m = 0; m < 256; m++) begin
                set_src(8'(m));
                chk("R4 R5 arbitration", outv(), expect_pick(8'(m), p));
            end
        end
        set_src(8'h00);

        // R3 masking
        cfg(2'd1, 8'h00); cfg(2'd2, 8'h44);
        cfg(2'd0, 8'h3F);
        set_src(8'hFF);
        chk("R3 global mask", irq_req, 0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] e;
            logic [7:0] x;
            e = (i < 6) ? (8'hBF & ~8'(1 << i)) : 8'hBF;
            x = 8'h44 & ~((i == 6) ? 8'h04 : 8'h00) & ~((i == 7) ? 8'h40 : 8'h00);
            cfg(2'd0, e); cfg(2'd2, x);
            set_src(8'(1 << i));
            chk("R3 source mask", irq_req, 0);
        end
        cfg(2'd0, 8'hBF); cfg(2'd2, 8'h44);
        set_src(8'h00);

        // R5 R6 R9 nesting: timer 2 low, INT3 high
        cfg(2'd2, 8'hC4);
        set_src(8'h20);
        chk("R2 timer2 vector low", outv(), (1 << 9) | 8'h2B);
        irq_ack = 1'b1; #1;
        chk("R9 no clear for timer2", tmr_clr, 0);
        @(negedge clk); irq_ack = 1'b0;
        chk("R6 svc after low ack", {svc_hi, svc_lo}, 1);
        chk("R5 same level blocked", irq_req, 0);
        set_src(8'hA0);
        chk("R5 high preempts low", outv(), (1 << 9) | (1 << 8) | 8'h3B);
        ack();
        chk("R6 svc after high ack", {svc_hi, svc_lo}, 3);
        chk("R5 nothing during high", irq_req, 0);
        ret();
        chk("R6 ret clears high first", {svc_hi, svc_lo}, 1);
        chk("R8 level INT3 still requests", outv(), (1 << 9) | (1 << 8) | 8'h3B);
        set_src(8'h20);
        chk("R5 low blocked in low service", irq_req, 0);
        ret();
        chk("R6 ret clears low", {svc_hi, svc_lo}, 0);
        chk("R9 timer2 stays pending", outv(), (1 << 9) | 8'h2B);
        set_src(8'h10);
        ack(); ret();
        chk("R9 serial stays pending", outv(), (1 << 9) | 8'h23);
        set_src(8'h00);
        cfg(2'd2, 8'h44);

        // R9 timer 0 and timer 1 clear strobes
        set_src(8'h02);
        irq_ack = 1'b1; #1;
        chk("R9 timer0 clear", tmr_clr, 1);
        @(negedge clk); irq_ack = 1'b0;
        chk("R9 strobe ends", tmr_clr, 0);
        ret();
        set_src(8'h08);
        irq_ack = 1'b1; #1;
        chk("R9 timer1 clear", tmr_clr, 2);
        @(negedge clk); irq_ack = 1'b0;
        ret();
        set_src(8'h00);

        // R7 INT2 in edge mode
        cfg(2'd2, 8'h45);
        ext_pin_n[2] = 1'b0;
        step(1);
        chk("R7 flag not yet", {xctl_q[1], irq_req}, 0);
        step(1);
        chk("R7 flag set", xctl_q[1], 1);
        chk("R7 INT2 vector", outv(), (1 << 9) | 8'h33);
        ack();
        chk("R7 ack clears flag", xctl_q[1], 0);
        step(3);
        chk("R7 held low no retrigger", xctl_q[1], 0);
        ret();
        chk("R7 no request after ret", irq_req, 0);
        ext_pin_n[2] = 1'b1;
        step(2);
        chk("R7 rising edge ignored", xctl_q[1], 0);

        // R7 INT0 in edge mode
        ext01_type = 2'b01;
        step(1);
        ext_pin_n[0] = 1'b0;
        step(2);
        chk("R7 INT0 flag", ext01_flag, 1);
        chk("R7 INT0 vector", outv(), (1 << 9) | 8'h03);
        ext_pin_n[0] = 1'b1;
        ack();
        chk("R7 INT0 flag cleared", ext01_flag, 0);
        ret();
        ext01_type = 2'b00;

        // R10 software flag write for INT3
        cfg(2'd2, 8'h54);
        cfg(2'd2, 8'h74);
        chk("R10 INT3 flag by write", xctl_q[5], 1);
        chk("R10 INT3 request", outv(), (1 << 9) | 8'h3B);
        cfg(2'd2, 8'h54);
        chk("R10 INT3 flag cleared by write", {xctl_q[5], irq_req}, 0);

        // R8 level mode keeps no flag and survives ack
        cfg(2'd2, 8'h44);
        ext_pin_n[2] = 1'b0;
        step(1);
        chk("R8 level request", outv(), (1 << 9) | 8'h33);
        step(2);
        chk("R8 no flag", xctl_q[1], 0);
        ack(); ret();
        chk("R8 request after ack", outv(), (1 << 9) | 8'h33);
        ext_pin_n[2] = 1'b1;
        step(1);
        chk("R8 request follows pin", irq_req, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule